// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of register stages, eight by default, that is filled either all at once from a parallel word or one bit at a time from a serial input. Only the last stage is visible, as the serial output. A typical use is converting a sampled byte into a bit stream: load the word, then shift it out with the most significant stage first.

The select input is sampled on each rising edge of the system clock. When it is low, the whole parallel word is captured. When it is high, the contents move one stage toward the output and the serial input fills the first stage. A hold input acts as a synchronous clock enable. While it is high, every stage keeps its value. This lets the system clock run freely while the register is stopped and restarted on command.

An active-low clear empties every stage at once, whatever the other inputs are doing. The end of the clear is synchronized to the clock, so the first load or shift after it happens on a known edge.

Top module: `psr_top`

## Requirements
- R1: While `clear_n` is low, every stage is zero and `ser_out` reads 0. Asserting `clear_n` takes effect at once, with no clock edge needed.
- R2: After `clear_n` rises, the first two rising clock edges leave all stages at zero. The first load or shift acts on the third edge.
- R3: With `hold` low and `shift_sel` low, a rising edge copies `par_in[i]` into stage i, where stage 0 is nearest the serial input and stage WIDTH-1 drives `ser_out`. Right after that edge, `ser_out` equals `par_in[WIDTH-1]`.
- R4: During a load, the level on `ser_in` has no effect. A word loaded with `ser_in` high shifts out exactly as loaded.
- R5: With `hold` low and `shift_sel` high, a rising edge moves stage i into stage i+1 and puts `ser_in` into stage 0. A loaded word therefore leaves `ser_out` in the order `par_in[WIDTH-1]`, `par_in[WIDTH-2]`, ..., `par_in[0]`.
- R6: A bit shifted in on `ser_in` reaches `ser_out` on exactly the WIDTH-th shift. After WIDTH shifts with `ser_in` low, the output stays 0.
- R7: While `hold` is high, no stage changes, whatever `shift_sel`, `ser_in` and `par_in` are. Shifting after `hold` falls continues the interrupted sequence.
- R8: `hold` also blocks a load: a rising edge with `hold` high and `shift_sel` low leaves the stages unchanged.
- R9: Asserting `clear_n` in the middle of a shift sequence discards all remaining stages. Later shifts with `ser_in` low produce only zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; state changes on its rising edge |
| hold | input | 1 | Synchronous clock enable, active low; high freezes all stages |
| clear_n | input | 1 | Active-low clear; asynchronous assertion, synchronized release |
| shift_sel | input | 1 | 1 = shift toward the output, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 on a shift |
| par_in | input | WIDTH | Parallel word; bit i loads stage i |
| ser_out | output | 1 | Content of the last stage (WIDTH-1) |

## Verification
Hidden-stage corruption is the main concern. The bench freezes the register partway through a word while offering a load, serial ones and a new word, then checks every remaining bit as it shifts out. A design that let a load or shift slip past the hold input would show a wrong bit after the pause. A load done with the serial input high, followed by a full drain, exposes a design that let the serial input leak in during a load: a stray one would appear at the tail of the word. A clear applied mid-stream is checked before the next clock edge, which catches a synchronous clear, and afterwards through a full drain, which catches a clear that missed some stages. Counting the zero cycles after clear release catches a release that is early or late by an edge.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Action taken by every stage on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2
    } psr_act_e;

    // Control inputs sampled at the clock edge
    typedef struct packed {
        logic live;
        logic hold;
        logic shift_sel;
    } psr_ctl_t;

    localparam int unsigned PSR_SYNC_DEPTH = 2;

    function automatic psr_act_e psr_decode(input psr_ctl_t c);
        psr_act_e a;
        if (!c.live || c.hold) begin
            a = ACT_HOLD;
        end else if (c.shift_sel) begin
            a = ACT_SHIFT;
        end else begin
            a = ACT_LOAD;
        end
        return a;
    endfunction

endpackage

// File: rtl/psr_release_sync.sv
module psr_release_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic clear_n,
    output logic live
);
    logic [DEPTH-1:0] chain;

    // Assert immediately, release after DEPTH rising edges
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], 1'b1};
        end
    end

    assign live = chain[DEPTH-1];
endmodule

// File: rtl/psr_ctl_decode.sv
module psr_ctl_decode
    import psr_pkg::*;
(
    input  logic     live,
    input  logic     hold,
    input  logic     shift_sel,
    output psr_act_e act
);
    psr_ctl_t ctl;

    always_comb begin
        ctl.live      = live;
        ctl.hold      = hold;
        ctl.shift_sel = shift_sel;
        act           = psr_decode(ctl);
    end
endmodule

// File: rtl/psr_stage.sv
module psr_stage
    import psr_pkg::*;
(
    input  logic     clk,
    input  logic     live,
    input  psr_act_e act,
    input  logic     par_bit,
    input  logic     prev_bit,
    output logic     q
);
    always_ff @(posedge clk or negedge live) begin
        if (!live) begin
            q <= 1'b0;
        end else begin
            case (act)
                ACT_SHIFT: q <= prev_bit;
                ACT_LOAD:  q <= par_bit;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/psr_top.sv
module psr_top
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             hold,
    input  logic             clear_n,
    input  logic             shift_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic             live;
    psr_act_e         act;
    logic [WIDTH-1:0] stage_q;

    psr_release_sync #(.DEPTH(PSR_SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .clear_n (clear_n),
        .live    (live)
    );

    psr_ctl_decode u_dec (
        .live      (live),
        .hold      (hold),
        .shift_sel (shift_sel),
        .act       (act)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prev;
        if (i == 0) begin : g_head
            assign prev = ser_in;
        end else begin : g_body
            assign prev = stage_q[i-1];
        end
        psr_stage u_st (
            .clk      (clk),
            .live     (live),
            .act      (act),
            .par_bit  (par_in[i]),
            .prev_bit (prev),
            .q        (stage_q[i])
        );
    end

    assign ser_out = stage_q[LAST];
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             hold,
    input logic             clear_n,
    input logic             shift_sel,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_out,
    input logic             live,
    input logic [WIDTH-1:0] stage_q
);
    // R1: clear forces the output low
    always @(negedge clk) begin
        if (clear_n === 1'b0) begin
            assert_clear_out_R1: assert (ser_out == 1'b0);
        end
    end

    // R2: stages stay empty until the release has propagated
    assert_release_empty_R2: assert property (@(posedge clk) disable iff (!clear_n)
        !live |-> stage_q == '0);

    // R3: load captures the parallel word
    assert_load_word_R3: assert property (@(posedge clk) disable iff (!clear_n)
        (live && !hold && !shift_sel) |=> stage_q == $past(par_in));

    // R5: shift moves toward the output and takes the serial bit
    assert_shift_move_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (live && !hold && shift_sel) |=>
            (stage_q[0] == $past(ser_in)) && (ser_out == $past(stage_q[WIDTH-2])));

    // R7: hold freezes every stage
    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (live && hold) |=> $stable(stage_q));
endmodule

bind psr_top psr_checker #(.WIDTH(WIDTH)) u_psr_chk (
    .clk       (clk),
    .hold      (hold),
    .clear_n   (clear_n),
    .shift_sel (shift_sel),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .ser_out   (ser_out),
    .live      (live),
    .stage_q   (stage_q)
);

// File: tb/test_psr_top.sv
`timescale 1ns/1ps
module test_psr_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         hold = 1'b0;
    logic         clear_n = 1'b0;
    logic         shift_sel = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    psr_top #(.WIDTH(W)) i_psr_top (
        .clk(clk), .hold(hold), .clear_n(clear_n), .shift_sel(shift_sel),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic exp);
        total++;
        if (ser_out !== exp) begin
            bad++;
            $display("FAIL %s: ser_out=%b expected=%b at %0t", req, ser_out, exp, $time);
        end
    endtask

    // Drive inputs after a falling edge, pass one rising edge, return at the next falling edge
    task automatic cyc(input logic h, input logic sel, input logic s, input logic [W-1:0] p);
        hold = h; shift_sel = sel; ser_in = s; par_in = p;
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 8'hFF);
            check("R1", 1'b0);
        end
        clear_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 8'hFF);
        check("R2", 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 8'hFF);
        check("R2", 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 8'hFF);
        check("R2", 1'b1);
    endtask

    task automatic t_load_shift(input logic [W-1:0] pat);
        cyc(1'b0, 1'b0, 1'b1, pat);      // load, ser_in high is ignored (R4)
        check("R3", pat[W-1]);
        for (int k = W-2; k >= 0; k--) begin
            cyc(1'b0, 1'b1, 1'b0, ~pat);
            check("R5", pat[k]);
        end
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b1, 1'b0, ~pat);
            check("R4", 1'b0);
        end
    endtask

    task automatic t_serial_delay();
        for (int k = 1; k <= W; k++) begin
            cyc(1'b0, 1'b1, (k == 1), 8'hFF);
            check("R6", (k == W));
        end
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R6", 1'b0);
    endtask

    task automatic t_hold();
        logic [W-1:0] pat = 8'hA5;
        cyc(1'b0, 1'b0, 1'b0, pat);
        check("R3", pat[7]);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R5", pat[6]);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R5", pat[5]);
        cyc(1'b1, 1'b1, 1'b1, 8'h00);
        check("R7", pat[5]);
        cyc(1'b1, 1'b0, 1'b1, 8'h5A);
        check("R8", pat[5]);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R8", pat[5]);
        cyc(1'b1, 1'b1, 1'b1, 8'hFF);
        check("R7", pat[5]);
        for (int k = 4; k >= 0; k--) begin
            cyc(1'b0, 1'b1, 1'b0, 8'h00);
            check("R7", pat[k]);
        end
    endtask

    task automatic t_clear_mid();
        cyc(1'b0, 1'b0, 1'b0, 8'hFF);
        check("R3", 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R5", 1'b1);
        #2 clear_n = 1'b0;
        #1 check("R9", 1'b0);   // before the next rising edge: asynchronous
        @(negedge clk);
        clear_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R2", 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R2", 1'b0);
        for (int k = 0; k < W; k++) begin
            cyc(1'b0, 1'b1, 1'b0, 8'h00);
            check("R9", 1'b0);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_shift(8'hC3);
        t_load_shift(8'h5E);
        t_serial_delay();
        t_hold();
        t_clear_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule